// File: doc/BRIEF.md
# Quadrature Subcarrier Phase Generator

This block turns a clock running at four times the color subcarrier frequency into the switching references for a pair of balanced chroma modulators. A two-bit phase index steps through four quarter-cycle positions, one per clock. The U carrier sign follows the 0° reference. The V carrier sign follows the 90° reference. In PAL mode the V carrier flips between 90° and 270° on alternate horizontal lines. In NTSC mode it stays at 90°.

A line strobe toggles a line-parity flag while PAL mode is selected. The V carrier adopts a new parity only when the phase index wraps back to 0. This keeps every carrier half-cycle whole, so no runt pulse is produced. The block also supports a 1x-reference mode. In that mode the 4x clock comes from an external multiplier, and the 1x subcarrier reference is synchronized into the 4x domain. A rising edge of that reference realigns the phase index so that index 0 tracks the reference. In the direct 4x mode the reference input is ignored and the counter runs free.

Top module: `qsp_subcarrier_gen`

## Requirements
- R1: Outside reset and realignment, `phase_idx` advances by one on every clock edge, in the order 0, 1, 2, 3, 0.
- R2: A clock edge that samples `rst` high sets `phase_idx` to 0, clears `line_par` and returns the applied V phase to 90°. These values are visible right after that edge.
- R3: `u_pos` is 1 while `phase_idx` is 0 or 1, and 0 while it is 2 or 3.
- R4: With `pal_mode` low, `line_par` is 0 after every edge and `line_strobe` has no effect. Once the index has wrapped to 0 since NTSC was entered, `v_pos` is 1 exactly while `phase_idx` is 1 or 2 (the 90° pattern).
- R5: With `pal_mode` high, every edge that samples `line_strobe` high inverts `line_par`. All other edges hold it.
- R6: The applied V phase is 270° when it is 1 and 90° when it is 0. At 270°, `v_pos` is the inverse of the 90° pattern. The applied phase is loaded only on an edge where `phase_idx` becomes 0. It takes the value `line_par` held just before that edge.
- R7: With `ref_1x_mode` high, `fsc_ref` passes through SYNC_STAGES flops (default 2). If edge k is the first to sample `fsc_ref` high after it was low, `phase_idx` is 0 after edge k+SYNC_STAGES.
- R8: With `ref_1x_mode` low, `fsc_ref` has no effect and `phase_idx` keeps counting as in R1.
- R9: When `pal_mode` falls, `line_par` is 0 after the next edge. `v_pos` returns to the 90° pattern after the next wrap to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst | input | 1 | Synchronous active-high reset |
| pal_mode | input | 1 | 1 selects PAL line alternation, 0 selects NTSC |
| ref_1x_mode | input | 1 | 1: clock comes from an external multiplier and `fsc_ref` realigns the index; 0: direct 4x clock |
| fsc_ref | input | 1 | 1x subcarrier reference, asynchronous to `clk` |
| line_strobe | input | 1 | One-cycle pulse per horizontal line |
| u_pos | output | 1 | U carrier sign, 1 = positive half |
| v_pos | output | 1 | V carrier sign, 1 = positive half |
| phase_idx | output | 2 | Current quarter-cycle position, 0..3 |
| line_par | output | 1 | PAL line-parity flag, 1 requests 270° |

## Verification
The hardest situation to reach is a line strobe that lands on the very edge where the index wraps to 0. At that edge the old parity must be applied and the new one must wait a full carrier cycle. The PAL stimulus therefore spaces strobes seven clocks apart, which walks them through every index position, including the wrap edge. A second hard case is a phase jump of the 1x reference. The stimulus shifts the reference pattern mid-run, so the forced return to 0 lands from a non-final index while the V phase is inverted.

// File: rtl/qsp_pkg.sv
package qsp_pkg;

    localparam int QSP_PHASES = 4;
    localparam int IDX_W      = $clog2(QSP_PHASES);

    typedef logic [IDX_W-1:0] phase_idx_t;

    localparam phase_idx_t IDX_ZERO  = phase_idx_t'(0);
    localparam phase_idx_t IDX_ONE   = phase_idx_t'(1);
    localparam phase_idx_t IDX_QTR   = phase_idx_t'(QSP_PHASES / 4);
    localparam phase_idx_t IDX_HALF  = phase_idx_t'(QSP_PHASES / 2);
    localparam phase_idx_t IDX_3QTR  = phase_idx_t'((3 * QSP_PHASES) / 4);

    typedef enum logic {
        V_AT_90  = 1'b0,
        V_AT_270 = 1'b1
    } vphase_e;

    typedef struct packed {
        logic u_pos;
        logic v_pos;
    } carrier_t;

    function automatic logic u_sign_f(input phase_idx_t idx);
        return (idx < IDX_HALF);
    endfunction

    function automatic logic v90_sign_f(input phase_idx_t idx);
        return (idx >= IDX_QTR) && (idx < IDX_3QTR);
    endfunction

endpackage

// File: rtl/qsp_phase_counter.sv
module qsp_phase_counter
    import qsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_1x_mode,
    input  logic       fsc_ref,
    output phase_idx_t idx,
    output logic       wrap_next,
    output logic       align_hit
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ref_prev;
    logic                   ref_s;
    phase_idx_t             idx_next;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= fsc_ref;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], fsc_ref};
            end
        end
    endgenerate

    assign ref_s     = sync_q[SYNC_STAGES-1];
    assign align_hit = ref_1x_mode & ref_s & ~ref_prev;

    always_comb begin
        if (align_hit) idx_next = IDX_ZERO;
        else           idx_next = idx + IDX_ONE;
    end

    assign wrap_next = (idx_next == IDX_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= IDX_ZERO;
            ref_prev <= 1'b0;
        end else begin
            idx      <= idx_next;
            ref_prev <= ref_s;
        end
    end

    AST_RESET_IDX: assert property (@(posedge clk)
        rst |=> (idx == IDX_ZERO)); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        !align_hit |=> (idx == phase_idx_t'($past(idx) + IDX_ONE))); // R1
    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        align_hit |=> (idx == IDX_ZERO)); // R7
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
        !ref_1x_mode |=> (idx == phase_idx_t'($past(idx) + IDX_ONE))); // R8

endmodule

// File: rtl/qsp_line_parity.sv
module qsp_line_parity
    import qsp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pal_mode,
    input  logic    line_strobe,
    input  logic    wrap_next,
    output logic    line_par,
    output vphase_e v_phase
);

    logic line_par_d;

    always_comb begin
        if (!pal_mode)        line_par_d = 1'b0;
        else if (line_strobe) line_par_d = ~line_par;
        else                  line_par_d = line_par;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_par <= 1'b0;
            v_phase  <= V_AT_90;
        end else begin
            line_par <= line_par_d;
            if (wrap_next) v_phase <= vphase_e'(line_par);
        end
    end

    AST_NTSC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !pal_mode |=> !line_par); // R4
    AST_STROBE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (pal_mode && line_strobe) |=> (line_par != $past(line_par))); // R5
    AST_APPLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(v_phase) |-> $past(wrap_next || rst)); // R6

endmodule

// File: rtl/qsp_carrier_map.sv
module qsp_carrier_map
    import qsp_pkg::*;
(
    input  phase_idx_t idx,
    input  vphase_e    v_phase,
    output carrier_t   carrier
);

    logic v90;

    always_comb begin
        v90           = v90_sign_f(idx);
        carrier.u_pos = u_sign_f(idx);
        carrier.v_pos = (v_phase == V_AT_270) ? ~v90 : v90;
    end

endmodule

// File: rtl/qsp_subcarrier_gen.sv
module qsp_subcarrier_gen
    import qsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pal_mode,
    input  logic             ref_1x_mode,
    input  logic             fsc_ref,
    input  logic             line_strobe,
    output logic             u_pos,
    output logic             v_pos,
    output logic [IDX_W-1:0] phase_idx,
    output logic             line_par
);

    phase_idx_t idx;
    logic       wrap_next;
    logic       align_hit;
    vphase_e    v_phase;
    carrier_t   carrier;

    qsp_phase_counter #(.SYNC_STAGES(SYNC_STAGES)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .ref_1x_mode (ref_1x_mode),
        .fsc_ref     (fsc_ref),
        .idx         (idx),
        .wrap_next   (wrap_next),
        .align_hit   (align_hit)
    );

    qsp_line_parity u_parity (
        .clk         (clk),
        .rst         (rst),
        .pal_mode    (pal_mode),
        .line_strobe (line_strobe),
        .wrap_next   (wrap_next),
        .line_par    (line_par),
        .v_phase     (v_phase)
    );

    qsp_carrier_map u_map (
        .idx     (idx),
        .v_phase (v_phase),
        .carrier (carrier)
    );

    assign phase_idx = idx;
    assign u_pos     = carrier.u_pos;
    assign v_pos     = carrier.v_pos;

    AST_U_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(u_pos) |-> (phase_idx == IDX_ZERO)); // R3
    AST_V90_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(v_pos) && $stable(v_phase) && (v_phase == V_AT_90)) |-> (phase_idx == IDX_ONE)); // R4

endmodule

// File: tb/qsp_subcarrier_gen_tb_top.sv
`timescale 1ns/1ps
module qsp_subcarrier_gen_tb_top;

    localparam int SYNC = 2;

    typedef struct packed {
        logic [1:0] idx;
        logic       u;
        logic       v;
        logic       lp;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pal_mode = 1'b0;
    logic       ref_1x_mode = 1'b0;
    logic       fsc_ref = 1'b0;
    logic       line_strobe = 1'b0;
    logic       u_pos, v_pos, line_par;
    logic [1:0] phase_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    // Reference model state
    logic [1:0]      m_idx  = 2'd0;
    logic [SYNC-1:0] m_sync = '0;
    logic            m_prev = 1'b0;
    logic            m_lp   = 1'b0;
    logic            m_app  = 1'b0;

    always #2 clk = ~clk;

    qsp_subcarrier_gen #(.SYNC_STAGES(SYNC)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .pal_mode    (pal_mode),
        .ref_1x_mode (ref_1x_mode),
        .fsc_ref     (fsc_ref),
        .line_strobe (line_strobe),
        .u_pos       (u_pos),
        .v_pos       (v_pos),
        .phase_idx   (phase_idx),
        .line_par    (line_par)
    );

    task automatic check(input string tag, input string what, input int got, input int expv);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the predicted outputs
    task automatic step(input logic r, input logic pal, input logic strobe,
                        input logic m1x, input logic fref, input string tag);
        logic       hit, wrap, s_last;
        logic [1:0] nidx;
        exp_t       e;
        @(negedge clk);
        rst = r; pal_mode = pal; line_strobe = strobe;
        ref_1x_mode = m1x; fsc_ref = fref;
        if (r) begin
            m_idx = 2'd0; m_sync = '0; m_prev = 1'b0; m_lp = 1'b0; m_app = 1'b0;
        end else begin
            s_last = m_sync[SYNC-1];
            hit    = m1x && s_last && !m_prev;
            nidx   = hit ? 2'd0 : m_idx + 2'd1;
            wrap   = (nidx == 2'd0);
            m_prev = s_last;
            m_sync = {m_sync[SYNC-2:0], fref};
            if (wrap) m_app = m_lp;
            m_lp   = pal ? (strobe ? !m_lp : m_lp) : 1'b0;
            m_idx  = nidx;
        end
        e.idx = m_idx;
        e.u   = (m_idx == 2'd0) || (m_idx == 2'd1);
        e.v   = ((m_idx == 2'd1) || (m_idx == 2'd2)) ^ m_app;
        e.lp  = m_lp;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "phase_idx", int'(phase_idx), int'(e.idx));
                check(t, "u_pos",     int'(u_pos),     int'(e.u));
                check(t, "v_pos",     int'(v_pos),     int'(e.v));
                check(t, "line_par",  int'(line_par),  int'(e.lp));
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: reset state
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R2");
        // R1 R3 R4: NTSC free run, strobes must be ignored
        for (int i = 0; i < 14; i++) step(0, 0, (i % 3) == 0, 0, 0, "R1 R3 R4");
        // R5 R6: PAL, strobes every 7 cycles walk across all index positions
        for (int i = 0; i < 44; i++) step(0, 1, (i % 7) == 2, 0, 0, "R5 R6");
        // R6: back-to-back strobes
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 0, "R6");
        // R9: return to NTSC
        for (int i = 0; i < 10; i++) step(0, 0, (i % 2) == 0, 0, 0, "R9");
        // R7: 1x reference, PAL active, then a phase jump of the reference
        for (int i = 0; i < 24; i++) step(0, 1, (i % 5) == 1, 1, ((i + 1) % 4) < 2, "R7");
        for (int i = 0; i < 24; i++) step(0, 1, (i % 6) == 3, 1, ((i + 3) % 4) < 2, "R7");
        // R8: direct 4x mode, reference toggles must be ignored
        for (int i = 0; i < 16; i++) step(0, 1, (i % 9) == 4, 0, ((i * 5) % 3) == 0, "R8");
        // R2: mid-run reset while V phase may be inverted
        step(1, 1, 1, 0, 0, "R2");
        for (int i = 0; i < 10; i++) step(0, 1, (i % 4) == 0, 0, 0, "R2");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule